// File: doc/BRIEF.md
# Process-Tagged Address Translation Cache

This block holds a small set of recent virtual-page to physical-frame translations for a 32-bit virtual space divided into 4 KB pages. Each stored translation belongs to one process and carries its own read, write and execute rights. Translations from several processes can sit in the cache together, because a lookup only hits when both the page number and the process tag match.

A lookup presents a virtual address, the running process tag and an access kind. In the same cycle the block reports a hit with the physical address, a protection fault, or a miss. A miss is left for an external page walker to resolve. The walker then writes the translation through the refill port. Flush controls drop either every translation or only those that belong to one process. Storage is fully associative. A refill takes an empty slot first and otherwise evicts in round-robin order.

Top module: `pid_tlb`

## Requirements
- R1: On a hit, `lk_paddr_o` is the stored 20-bit frame number in bits 31:12 followed by `lk_vaddr_i[11:0]` unchanged in bits 11:0. The page number is `lk_vaddr_i[31:12]`.
- R2: A hit requires a valid entry whose page number and process tag both equal the lookup's. The same page number under a different tag is a miss.
- R3: Access kinds on `lk_acc_i` are 00 load, 01 store, 10 instruction fetch and 11 reserved. A load needs the read right, a store needs the write right and a fetch needs the execute right. The reserved code is never allowed. Rights are given on `rf_perm_i` as bit 2 read, bit 1 write and bit 0 execute.
- R4: When an entry matches but its rights do not allow the access, `lk_fault_o` is 1, `lk_hit_o` is 0 and `lk_paddr_o` is 0.
- R5: When no entry matches, or when `lk_req_i` is 0, `lk_hit_o`, `lk_fault_o` and `lk_paddr_o` are all 0.
- R6: The cache is fully associative with 16 entries. Any 16 distinct page and tag pairs can be resident at once.
- R7: A refill that does not duplicate a resident entry goes to the lowest-numbered empty slot. If every slot is full, it goes to the slot under a round-robin pointer. That pointer starts at slot 0 after reset and advances by one only when it is used for an eviction.
- R8: A refill whose page number and tag equal a resident entry overwrites that entry in place and does not occupy a second slot.
- R9: A whole-cache flush clears every entry at the next clock edge.
- R10: A per-process flush clears, at the next clock edge, only the entries whose tag equals `fl_pid_i`.
- R11: When a flush and a refill share a clock edge, the flush acts first and the refilled entry remains valid afterwards.
- R12: After reset every entry is empty, so every lookup misses.
- R13: A lookup is combinational. A refill becomes visible only after the next rising edge, so a lookup in the refill's own cycle sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_req_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Lookup virtual address |
| lk_pid_i | input | 8 | Running process tag |
| lk_acc_i | input | 2 | Access kind (00 load, 01 store, 10 fetch, 11 reserved) |
| lk_hit_o | output | 1 | Translation found and access allowed |
| lk_fault_o | output | 1 | Translation found but access not allowed |
| lk_paddr_o | output | 32 | Physical address on hit, else 0 |
| rf_req_i | input | 1 | Write a translation at the next edge |
| rf_vpn_i | input | 20 | Refill virtual page number |
| rf_pid_i | input | 8 | Refill process tag |
| rf_pfn_i | input | 20 | Refill physical frame number |
| rf_perm_i | input | 3 | Refill rights {read, write, execute} |
| fl_all_i | input | 1 | Clear every entry |
| fl_pid_req_i | input | 1 | Clear entries of one process |
| fl_pid_i | input | 8 | Tag to clear on a per-process flush |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a refill and a flush on the same edge. The bench fills the cache completely, then raises a whole-cache flush together with a refill of a new page. It judges the result by lookups afterwards: the new page must hit and older residents must miss. The second pair is a lookup and a refill in the same cycle. The bench drives both together and expects a miss before the edge and a hit after it.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'b00,
      ACC_STORE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_e;

   typedef struct packed {
      logic rd;
      logic wr;
      logic ex;
   } perm_t;

   function automatic logic perm_allows(perm_t p, acc_e a);
      case (a)
         ACC_LOAD:  return p.rd;
         ACC_STORE: return p.wr;
         ACC_FETCH: return p.ex;
         default:   return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/ptlb_store.sv
module ptlb_store
   import ptlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int PID_W   = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [VPN_W-1:0]   lk_vpn_i,
   input  logic [PID_W-1:0]   lk_pid_i,
   input  logic               wr_en_i,
   input  logic [IDX_W-1:0]   wr_idx_i,
   input  logic [VPN_W-1:0]   wr_vpn_i,
   input  logic [PID_W-1:0]   wr_pid_i,
   input  logic [PFN_W-1:0]   wr_pfn_i,
   input  perm_t              wr_perm_i,
   input  logic               fl_all_i,
   input  logic               fl_pid_req_i,
   input  logic [PID_W-1:0]   fl_pid_i,
   output logic [ENTRIES-1:0] lk_match_o,
   output logic [ENTRIES-1:0] rf_match_o,
   output logic [ENTRIES-1:0] valid_o,
   output logic [PFN_W-1:0]   lk_pfn_o,
   output perm_t              lk_perm_o
);

   logic [VPN_W-1:0] vpn_q  [ENTRIES];
   logic [PID_W-1:0] pid_q  [ENTRIES];
   logic [PFN_W-1:0] pfn_q  [ENTRIES];
   perm_t            perm_q [ENTRIES];
   logic [ENTRIES-1:0] valid_q;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic wr_here;
      logic kill;
      assign wr_here = wr_en_i && (wr_idx_i == IDX_W'(i));
      assign kill    = fl_all_i || (fl_pid_req_i && (pid_q[i] == fl_pid_i));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            valid_q[i] <= 1'b0;
         end else if (wr_here) begin
            valid_q[i] <= 1'b1;
         end else if (kill) begin
            valid_q[i] <= 1'b0;
         end
      end

      always_ff @(posedge clk_i) begin
         if (wr_here) begin
            vpn_q[i]  <= wr_vpn_i;
            pid_q[i]  <= wr_pid_i;
            pfn_q[i]  <= wr_pfn_i;
            perm_q[i] <= wr_perm_i;
         end
      end

      assign lk_match_o[i] = valid_q[i] && (vpn_q[i] == lk_vpn_i) && (pid_q[i] == lk_pid_i);
      assign rf_match_o[i] = valid_q[i] && (vpn_q[i] == wr_vpn_i) && (pid_q[i] == wr_pid_i);

      // R10: a per-process flush of this entry's tag empties it unless refilled
      p_pid_flush_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (fl_pid_req_i && valid_q[i] && (pid_q[i] == fl_pid_i) && !wr_here) |=> !valid_q[i]);
   end

   assign valid_o = valid_q;

   always_comb begin
      lk_pfn_o  = '0;
      lk_perm_o = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_match_o[i]) begin
            lk_pfn_o  = lk_pfn_o | pfn_q[i];
            lk_perm_o = lk_perm_o | perm_q[i];
         end
      end
   end

   // R8: refills never create two entries answering the same lookup
   p_single_match_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(lk_match_o));

   // R9: a whole flush without refill leaves nothing resident
   p_flush_all_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fl_all_i && !wr_en_i) |=> (valid_q == '0));

endmodule

// File: rtl/ptlb_victim.sv
module ptlb_victim #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               rf_req_i,
   input  logic [ENTRIES-1:0] valid_i,
   input  logic [ENTRIES-1:0] rf_match_i,
   output logic               wr_en_o,
   output logic [IDX_W-1:0]   wr_idx_o
);

   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] rr_nxt;
   logic [IDX_W-1:0] dup_idx;
   logic [IDX_W-1:0] free_idx;
   logic             dup_any;
   logic             full;
   logic             evict;

   if ((ENTRIES & (ENTRIES - 1)) == 0) begin : g_pow2
      assign rr_nxt = rr_q + 1'b1;
   end else begin : g_wrap
      assign rr_nxt = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
   end

   always_comb begin
      dup_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (rf_match_i[i]) dup_idx = IDX_W'(i);
      end
   end

   always_comb begin
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_i[i]) free_idx = IDX_W'(i);
      end
   end

   assign dup_any = |rf_match_i;
   assign full    = &valid_i;
   assign evict   = rf_req_i && !dup_any && full;
   assign wr_en_o = rf_req_i;
   assign wr_idx_o = dup_any ? dup_idx : (full ? rr_q : free_idx);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rr_q <= '0;
      else if (evict) rr_q <= rr_nxt;
   end

   // R7: the round-robin pointer holds when no refill arrives
   p_ptr_hold_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rf_req_i |=> $stable(rr_q));

   // R7: a non-full cache never chooses an occupied slot for a new page
   p_free_first_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rf_req_i && !dup_any && !full) |-> !valid_i[wr_idx_o]);

endmodule

// File: rtl/ptlb_check.sv
module ptlb_check
   import ptlb_pkg::*;
#(
   parameter int PFN_W  = 20,
   parameter int OFS_W  = 12
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   req_i,
   input  logic                   match_i,
   input  perm_t                  perm_i,
   input  logic [1:0]             acc_i,
   input  logic [PFN_W-1:0]       pfn_i,
   input  logic [OFS_W-1:0]       ofs_i,
   output logic                   hit_o,
   output logic                   fault_o,
   output logic [PFN_W+OFS_W-1:0] paddr_o
);

   logic allowed;

   assign allowed = perm_allows(perm_i, acc_e'(acc_i));
   assign hit_o   = req_i && match_i && allowed;
   assign fault_o = req_i && match_i && !allowed;
   assign paddr_o = hit_o ? {pfn_i, ofs_i} : '0;

   // R4: hit and fault never coincide
   p_hit_fault_excl_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hit_o && fault_o));

   // R5: without a request nothing is reported
   p_idle_quiet_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i |-> (!hit_o && !fault_o && paddr_o == '0));

endmodule

// File: rtl/pid_tlb.sv
module pid_tlb
   import ptlb_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int OFS_W   = 12,
   parameter int PFN_W   = 20,
   parameter int PID_W   = 8,
   parameter int ENTRIES = 16,
   localparam int VPN_W  = VA_W - OFS_W,
   localparam int PA_W   = PFN_W + OFS_W,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             lk_req_i,
   input  logic [VA_W-1:0]  lk_vaddr_i,
   input  logic [PID_W-1:0] lk_pid_i,
   input  logic [1:0]       lk_acc_i,
   output logic             lk_hit_o,
   output logic             lk_fault_o,
   output logic [PA_W-1:0]  lk_paddr_o,
   input  logic             rf_req_i,
   input  logic [VPN_W-1:0] rf_vpn_i,
   input  logic [PID_W-1:0] rf_pid_i,
   input  logic [PFN_W-1:0] rf_pfn_i,
   input  logic [2:0]       rf_perm_i,
   input  logic             fl_all_i,
   input  logic             fl_pid_req_i,
   input  logic [PID_W-1:0] fl_pid_i
);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("pid_tlb: ENTRIES must be at least 2");
   end
   if (OFS_W < 1 || OFS_W >= VA_W) begin : g_bad_ofs
      $error("pid_tlb: OFS_W must lie inside the virtual address");
   end
   if (PID_W < 1) begin : g_bad_pid
      $error("pid_tlb: PID_W must be positive");
   end

   logic [ENTRIES-1:0] lk_match;
   logic [ENTRIES-1:0] rf_match;
   logic [ENTRIES-1:0] valid;
   logic [PFN_W-1:0]   hit_pfn;
   perm_t              hit_perm;
   logic               wr_en;
   logic [IDX_W-1:0]   wr_idx;

   ptlb_store #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .PID_W(PID_W)
   ) u_store (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .lk_vpn_i     (lk_vaddr_i[VA_W-1:OFS_W]),
      .lk_pid_i     (lk_pid_i),
      .wr_en_i      (wr_en),
      .wr_idx_i     (wr_idx),
      .wr_vpn_i     (rf_vpn_i),
      .wr_pid_i     (rf_pid_i),
      .wr_pfn_i     (rf_pfn_i),
      .wr_perm_i    (perm_t'(rf_perm_i)),
      .fl_all_i     (fl_all_i),
      .fl_pid_req_i (fl_pid_req_i),
      .fl_pid_i     (fl_pid_i),
      .lk_match_o   (lk_match),
      .rf_match_o   (rf_match),
      .valid_o      (valid),
      .lk_pfn_o     (hit_pfn),
      .lk_perm_o    (hit_perm)
   );

   ptlb_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rf_req_i   (rf_req_i),
      .valid_i    (valid),
      .rf_match_i (rf_match),
      .wr_en_o    (wr_en),
      .wr_idx_o   (wr_idx)
   );

   ptlb_check #(.PFN_W(PFN_W), .OFS_W(OFS_W)) u_check (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (lk_req_i),
      .match_i (|lk_match),
      .perm_i  (hit_perm),
      .acc_i   (lk_acc_i),
      .pfn_i   (hit_pfn),
      .ofs_i   (lk_vaddr_i[OFS_W-1:0]),
      .hit_o   (lk_hit_o),
      .fault_o (lk_fault_o),
      .paddr_o (lk_paddr_o)
   );

   // R11, R13: the slot written by a refill is resident after the edge, flush or not
   p_refill_lands_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en |=> valid[$past(wr_idx)]);

   // R1: a hit carries the page offset through unchanged
   p_offset_pass_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      lk_hit_o |-> (lk_paddr_o[OFS_W-1:0] == lk_vaddr_i[OFS_W-1:0]));

endmodule

// File: tb/pid_tlb_bench.sv
`timescale 1ns/1ps
module pid_tlb_bench;

   typedef struct {
      logic        hit;
      logic        fault;
      logic [31:0] pa;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_req = 1'b0;
   logic [31:0] lk_va = '0;
   logic [7:0]  lk_pid = '0;
   logic [1:0]  lk_acc = '0;
   logic        hit, fault;
   logic [31:0] pa;
   logic        rf_req = 1'b0;
   logic [19:0] rf_vpn = '0;
   logic [7:0]  rf_pid = '0;
   logic [19:0] rf_pfn = '0;
   logic [2:0]  rf_perm = '0;
   logic        fl_all = 1'b0;
   logic        fl_pr = 1'b0;
   logic [7:0]  fl_pid = '0;

   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t q[$];

   always #2.5 clk = ~clk;

   pid_tlb u_pid_tlb (
      .clk_i(clk), .rst_ni(rst_n),
      .lk_req_i(lk_req), .lk_vaddr_i(lk_va), .lk_pid_i(lk_pid), .lk_acc_i(lk_acc),
      .lk_hit_o(hit), .lk_fault_o(fault), .lk_paddr_o(pa),
      .rf_req_i(rf_req), .rf_vpn_i(rf_vpn), .rf_pid_i(rf_pid), .rf_pfn_i(rf_pfn),
      .rf_perm_i(rf_perm), .fl_all_i(fl_all), .fl_pid_req_i(fl_pr), .fl_pid_i(fl_pid)
   );

   // monitor: compares the live outputs against each queued expectation
   initial begin
      forever begin
         exp_t e;
         wait (q.size() != 0);
         e = q.pop_front();
         n_run++;
         if (hit !== e.hit || fault !== e.fault || pa !== e.pa) begin
            n_fail++;
            $display("FAIL %s: got hit=%b fault=%b pa=%h, expected hit=%b fault=%b pa=%h",
                     e.tag, hit, fault, pa, e.hit, e.fault, e.pa);
         end
      end
   end

   // driver: present a lookup at the falling edge and queue what it must give
   task automatic look(input logic req, input logic [31:0] va, input logic [7:0] pid,
                       input logic [1:0] acc, input logic eh, input logic ef,
                       input logic [31:0] epa, input string tag);
      @(negedge clk);
      lk_req = req; lk_va = va; lk_pid = pid; lk_acc = acc;
      #1;
      q.push_back('{eh, ef, epa, tag});
      wait (q.size() == 0);
   endtask

   task automatic edge_op(input logic rf, input logic [19:0] vpn, input logic [7:0] pid,
                          input logic [19:0] pfn, input logic [2:0] perm,
                          input logic fa, input logic fp, input logic [7:0] fpid);
      @(negedge clk);
      rf_req = rf; rf_vpn = vpn; rf_pid = pid; rf_pfn = pfn; rf_perm = perm;
      fl_all = fa; fl_pr = fp; fl_pid = fpid;
      @(posedge clk);
      #1;
      rf_req = 1'b0; fl_all = 1'b0; fl_pr = 1'b0;
   endtask

   task automatic refill(input logic [19:0] vpn, input logic [7:0] pid,
                         input logic [19:0] pfn, input logic [2:0] perm);
      edge_op(1'b1, vpn, pid, pfn, perm, 1'b0, 1'b0, 8'h00);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12: empty after reset
      look(1, 32'h0001_0123, 8'd1, 2'b00, 0, 0, 32'h0, "R12 reset empty");

      // R13: lookup in the refill cycle sees old contents
      @(negedge clk);
      rf_req = 1; rf_vpn = 20'h00010; rf_pid = 8'd1; rf_pfn = 20'hABCDE; rf_perm = 3'b110;
      lk_req = 1; lk_va = 32'h0001_0123; lk_pid = 8'd1; lk_acc = 2'b00;
      #1;
      q.push_back('{1'b0, 1'b0, 32'h0, "R13 same-cycle refill miss"});
      wait (q.size() == 0);
      @(posedge clk); #1; rf_req = 0;
      look(1, 32'h0001_0123, 8'd1, 2'b00, 1, 0, 32'hABCD_E123, "R13 R1 load hit after edge");
      look(1, 32'h0001_0FFF, 8'd1, 2'b01, 1, 0, 32'hABCD_EFFF, "R3 store allowed");
      look(1, 32'h0001_0040, 8'd1, 2'b10, 0, 1, 32'h0, "R3 R4 fetch without execute");
      look(1, 32'h0001_0040, 8'd1, 2'b11, 0, 1, 32'h0, "R3 reserved kind faults");
      look(1, 32'h0001_0040, 8'd2, 2'b00, 0, 0, 32'h0, "R2 other tag misses");
      look(1, 32'h0002_0040, 8'd1, 2'b00, 0, 0, 32'h0, "R5 other page misses");
      look(0, 32'h0001_0123, 8'd1, 2'b00, 0, 0, 32'h0, "R5 no request quiet");

      // R2: same page, second process, execute only
      refill(20'h00010, 8'd2, 20'h11111, 3'b001);
      look(1, 32'h0001_0456, 8'd2, 2'b10, 1, 0, 32'h1111_1456, "R2 second tag fetch hit");
      look(1, 32'h0001_0456, 8'd2, 2'b00, 0, 1, 32'h0, "R4 second tag load faults");
      look(1, 32'h0001_0456, 8'd1, 2'b00, 1, 0, 32'hABCD_E456, "R2 first tag still hits");

      // R8: same page and tag overwrites in place
      refill(20'h00010, 8'd1, 20'h22222, 3'b001);
      look(1, 32'h0001_0789, 8'd1, 2'b10, 1, 0, 32'h2222_2789, "R8 overwritten frame");
      look(1, 32'h0001_0789, 8'd1, 2'b00, 0, 1, 32'h0, "R8 overwritten rights");

      // R10: per-process flush of tag 2 only
      edge_op(0, '0, '0, '0, '0, 1'b0, 1'b1, 8'd2);
      look(1, 32'h0001_0000, 8'd2, 2'b10, 0, 0, 32'h0, "R10 flushed tag misses");
      look(1, 32'h0001_0000, 8'd1, 2'b10, 1, 0, 32'h2222_2000, "R10 other tag kept");

      // R6, R7: fill slots 1..15, empty slot reused before eviction
      for (int i = 0; i < 15; i++)
         refill(20'h00100 + 20'(i), 8'd3, 20'h50000 + 20'(i), 3'b100);
      for (int i = 0; i < 15; i++)
         look(1, {20'h00100 + 20'(i), 12'h0A5}, 8'd3, 2'b00, 1, 0,
              {20'h50000 + 20'(i), 12'h0A5}, "R6 resident entry hits");
      look(1, 32'h0001_0000, 8'd1, 2'b10, 1, 0, 32'h2222_2000, "R6 R7 sixteenth entry kept");

      // R7: round-robin eviction from slot 0, then slot 1
      refill(20'h00200, 8'd3, 20'h60000, 3'b100);
      look(1, 32'h0001_0000, 8'd1, 2'b10, 0, 0, 32'h0, "R7 slot 0 evicted");
      look(1, 32'h0020_0010, 8'd3, 2'b00, 1, 0, 32'h6000_0010, "R7 new page hits");
      look(1, 32'h0010_0010, 8'd3, 2'b00, 1, 0, 32'h5000_0010, "R7 slot 1 kept");
      refill(20'h00201, 8'd3, 20'h60001, 3'b100);
      look(1, 32'h0010_0010, 8'd3, 2'b00, 0, 0, 32'h0, "R7 slot 1 evicted");
      look(1, 32'h0010_1010, 8'd3, 2'b00, 1, 0, 32'h5000_1010, "R7 slot 2 kept");

      // R11: whole flush and refill on one edge
      edge_op(1, 20'h00300, 8'd4, 20'h70000, 3'b111, 1'b1, 1'b0, 8'd0);
      look(1, 32'h0030_0ABC, 8'd4, 2'b01, 1, 0, 32'h7000_0ABC, "R11 refill survives flush");
      look(1, 32'h0010_1010, 8'd3, 2'b00, 0, 0, 32'h0, "R11 older entry flushed");
      look(1, 32'h0020_1010, 8'd3, 2'b00, 0, 0, 32'h0, "R11 evicting entry flushed");

      // R9: whole flush alone
      edge_op(0, '0, '0, '0, '0, 1'b1, 1'b0, 8'd0);
      look(1, 32'h0030_0ABC, 8'd4, 2'b01, 0, 0, 32'h0, "R9 all flushed");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule